// File: doc/BRIEF.md
# Acquisition Run Sequencer

This block is the top of the acquisition control path. A one-cycle event flag comes in together with the code of the trigger type that won arbitration. If the system is armed when the flag arrives, the block raises a freeze line. That line halts the cyclic waveform memories at the front end before the event is overwritten. The block then holds the freeze until every acquisition computer that takes part has dropped its busy line. It then re-arms the front end with a single-cycle start pulse.

The freeze, the start pulse, a running event count and the latched trigger code travel together on one control bus. Busy lines pass through a parameterised synchroniser. A mask bit per computer removes absent machines from the all-clear condition. A minimum freeze width gives the computers time to raise busy before it is sampled. The freeze is registered one cycle after the flag. An elaboration-time check keeps the upstream latency plus this cycle within the allowed budget of clock cycles.

Top module: `acq_run_sequencer`

## Requirements
- R1: While reset is high, and in the first cycle after it, stop_o, start_o, evt_count and trig_type are all zero.
- R2: A sig_valid that arrives while stop_o is low (armed) raises stop_o on the next cycle. The same edge latches sig_type into trig_type and adds one to evt_count. This includes a sig_valid that arrives in the same cycle as a start pulse.
- R3: A sig_valid that arrives while stop_o is high has no effect: evt_count and trig_type keep their values.
- R4: Once raised, stop_o stays high for at least HOLD_MIN cycles.
- R5: stop_o stays high while any unmasked host_busy bit, delayed by SYNC_STAGES clocks, is 1. After the last such bit clears, stop_o falls after exactly SYNC_STAGES+1 edges, provided HOLD_MIN is already met.
- R6: start_o is a single-cycle pulse. It is high exactly in the cycle in which stop_o has just fallen, so stop_o never rises twice without a start pulse between the two rises.
- R7: A host_busy bit whose busy_mask bit is 1 has no effect on when stop_o falls.
- R8: run_begin clears evt_count and trig_type on the next edge and leaves stop_o unchanged. If it coincides with an accepted sig_valid, the count becomes 1 and trig_type takes sig_type.
- R9: evt_count wraps from 2^CNT_W-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_begin | input | 1 | Start of run: clears count and trigger code |
| sig_valid | input | 1 | One-cycle event signature flag |
| sig_type | input | TYPE_W | Code of the winning trigger type |
| host_busy | input | N_HOSTS | Busy line per acquisition computer |
| busy_mask | input | N_HOSTS | 1 excludes that computer from the all-clear |
| stop_o | output | 1 | Freeze front-end memories |
| start_o | output | 1 | One-cycle re-arm pulse |
| evt_count | output | CNT_W | Accepted event count |
| trig_type | output | TYPE_W | Trigger code of the last accepted event |

## Verification
The bench aims at a flag that lands in the start-pulse cycle. A design that treats that cycle as not yet armed would drop the event. It also sends repeated flags during a freeze, where a leaky guard would bump the count or overwrite the trigger code. Busy lines are held on masked and unmasked computers. A design that ignored the synchroniser delay would release the freeze too early or too late, and one that ignored the mask would hang. Counter wrap, run_begin in mid-freeze and the minimum freeze width with all computers idle are also exercised; a wrong hold timer shows up as a freeze that is too short.

// File: rtl/acq_run_pkg.sv
package acq_run_pkg;
   typedef enum logic {
      ST_ARMED  = 1'b0,
      ST_FROZEN = 1'b1
   } seq_state_t;
endpackage

// File: rtl/acq_busy_gate.sv
module acq_busy_gate #(
   parameter int N_HOSTS     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [N_HOSTS-1:0] busy,
   input  logic [N_HOSTS-1:0] mask,
   output logic               all_clear
);
   logic [N_HOSTS-1:0] busy_s;
   logic [N_HOSTS-1:0] live;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign busy_s = busy;
      end else begin : g_sync
         logic [N_HOSTS-1:0] stage [SYNC_STAGES];
         always_ff @(posedge clk) begin
            if (rst) stage[0] <= '0;
            else     stage[0] <= busy;
         end
         for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_stage
            always_ff @(posedge clk) begin
               if (rst) stage[k] <= '0;
               else     stage[k] <= stage[k-1];
            end
         end
         assign busy_s = stage[SYNC_STAGES-1];
      end
   endgenerate

   for (genvar h = 0; h < N_HOSTS; h++) begin : g_host
      assign live[h] = busy_s[h] & ~mask[h];
   end

   assign all_clear = ~|live;
endmodule

// File: rtl/acq_hold_timer.sv
module acq_hold_timer #(
   parameter int HOLD_MIN = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic done
);
   localparam int CW = $clog2(HOLD_MIN + 1);
   localparam logic [CW-1:0] LAST = CW'(HOLD_MIN - 1);

   logic [CW-1:0] cnt;

   assign done = (cnt >= LAST);

   always_ff @(posedge clk) begin
      if (rst || !run) cnt <= '0;
      else if (!done)  cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/acq_event_record.sv
module acq_event_record #(
   parameter int CNT_W  = 16,
   parameter int TYPE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              accept,
   input  logic [TYPE_W-1:0] type_in,
   output logic [CNT_W-1:0]  count,
   output logic [TYPE_W-1:0] type_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         count  <= '0;
         type_q <= '0;
      end else if (clear) begin
         count  <= accept ? CNT_W'(1) : '0;
         type_q <= accept ? type_in : '0;
      end else if (accept) begin
         count  <= count + 1'b1;
         type_q <= type_in;
      end
   end
endmodule

// File: rtl/acq_run_sequencer.sv
module acq_run_sequencer
   import acq_run_pkg::*;
#(
   parameter int N_HOSTS      = 4,
   parameter int TYPE_W       = 5,
   parameter int CNT_W        = 16,
   parameter int HOLD_MIN     = 4,
   parameter int SYNC_STAGES  = 2,
   parameter int UPSTREAM_CYC = 30,
   parameter int BUDGET_CYC   = 40
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               run_begin,
   input  logic               sig_valid,
   input  logic [TYPE_W-1:0]  sig_type,
   input  logic [N_HOSTS-1:0] host_busy,
   input  logic [N_HOSTS-1:0] busy_mask,
   output logic               stop_o,
   output logic               start_o,
   output logic [CNT_W-1:0]   evt_count,
   output logic [TYPE_W-1:0]  trig_type
);
   localparam int STOP_LAT = 1;

   generate
      if (N_HOSTS < 1)                          begin : g_bad_hosts  $error("N_HOSTS must be at least 1");     end
      if (TYPE_W < 1 || CNT_W < 1)              begin : g_bad_width  $error("widths must be positive");        end
      if (HOLD_MIN < 1)                         begin : g_bad_hold   $error("HOLD_MIN must be at least 1");    end
      if (SYNC_STAGES < 0)                      begin : g_bad_sync   $error("SYNC_STAGES cannot be negative"); end
      if (UPSTREAM_CYC + STOP_LAT > BUDGET_CYC) begin : g_bad_budget $error("stop latency over budget");       end
   endgenerate

   seq_state_t state;
   logic       all_clear;
   logic       hold_done;
   logic       accept;
   logic       release_now;

   acq_busy_gate #(.N_HOSTS(N_HOSTS), .SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(clk), .rst(rst), .busy(host_busy), .mask(busy_mask), .all_clear(all_clear)
   );

   acq_hold_timer #(.HOLD_MIN(HOLD_MIN)) u_hold (
      .clk(clk), .rst(rst), .run(state == ST_FROZEN), .done(hold_done)
   );

   assign accept      = (state == ST_ARMED) && sig_valid;
   assign release_now = (state == ST_FROZEN) && hold_done && all_clear;

   acq_event_record #(.CNT_W(CNT_W), .TYPE_W(TYPE_W)) u_rec (
      .clk(clk), .rst(rst), .clear(run_begin), .accept(accept),
      .type_in(sig_type), .count(evt_count), .type_q(trig_type)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= ST_ARMED;
         start_o <= 1'b0;
      end else begin
         start_o <= release_now;
         if (accept)           state <= ST_FROZEN;
         else if (release_now) state <= ST_ARMED;
      end
   end

   assign stop_o = (state == ST_FROZEN);
endmodule

// File: rtl/acq_run_sequencer_chk.sv
module acq_run_sequencer_chk #(
   parameter int TYPE_W   = 5,
   parameter int CNT_W    = 16,
   parameter int HOLD_MIN = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              run_begin,
   input logic              sig_valid,
   input logic [TYPE_W-1:0] sig_type,
   input logic              stop_o,
   input logic              start_o,
   input logic [CNT_W-1:0]  evt_count,
   input logic [TYPE_W-1:0] trig_type
);
   localparam int RW = $clog2(HOLD_MIN + 2);
   localparam logic [RW-1:0] SAT = RW'(HOLD_MIN);

   logic [RW-1:0] high_run;

   always_ff @(posedge clk) begin
      if (rst || !stop_o)     high_run <= '0;
      else if (high_run != SAT) high_run <= high_run + 1'b1;
   end

   AST_STOP_ON_SIG: assert property (@(posedge clk) disable iff (rst)
      (!stop_o && sig_valid) |=> (stop_o && trig_type == $past(sig_type))); // R2

   AST_FROZEN_IGNORES: assert property (@(posedge clk) disable iff (rst)
      (stop_o && !run_begin) |=> ($stable(evt_count) && $stable(trig_type))); // R3

   AST_HOLD_WIDTH: assert property (@(posedge clk) disable iff (rst)
      $fell(stop_o) |-> (high_run == SAT)); // R4

   AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      start_o |=> !start_o); // R6

   AST_START_WITH_FALL: assert property (@(posedge clk) disable iff (rst)
      start_o |-> $fell(stop_o)); // R6

   AST_FALL_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
      $fell(stop_o) |-> start_o); // R6

   AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (run_begin && (stop_o || !sig_valid)) |=> (evt_count == '0 && trig_type == '0)); // R8

   AST_RUN_KEEPS_STOP: assert property (@(posedge clk) disable iff (rst)
      (run_begin && stop_o) |=> (stop_o || start_o)); // R8
endmodule

bind acq_run_sequencer acq_run_sequencer_chk #(
   .TYPE_W(TYPE_W), .CNT_W(CNT_W), .HOLD_MIN(HOLD_MIN)
) u_chk (
   .clk(clk), .rst(rst), .run_begin(run_begin), .sig_valid(sig_valid),
   .sig_type(sig_type), .stop_o(stop_o), .start_o(start_o),
   .evt_count(evt_count), .trig_type(trig_type)
);

// File: tb/sim_acq_run_sequencer.sv
module sim_acq_run_sequencer;
   localparam int CLK_PERIOD = 10;
   localparam int NH    = 3;
   localparam int TW    = 5;
   localparam int CW    = 4;
   localparam int HOLD  = 3;
   localparam int SYNC  = 2;
   localparam int WATCHDOG = 20000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          run_begin = 1'b0;
   logic          sig_valid = 1'b0;
   logic [TW-1:0] sig_type = '0;
   logic [NH-1:0] host_busy = '0;
   logic [NH-1:0] busy_mask = '0;
   logic          stop_o, start_o;
   logic [CW-1:0] evt_count;
   logic [TW-1:0] trig_type;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acq_run_sequencer #(
      .N_HOSTS(NH), .TYPE_W(TW), .CNT_W(CW), .HOLD_MIN(HOLD), .SYNC_STAGES(SYNC)
   ) u0 (
      .clk(clk), .rst(rst), .run_begin(run_begin), .sig_valid(sig_valid),
      .sig_type(sig_type), .host_busy(host_busy), .busy_mask(busy_mask),
      .stop_o(stop_o), .start_o(start_o), .evt_count(evt_count), .trig_type(trig_type)
   );

   // Behavioural reference model
   bit            m_stop, m_start;
   int            m_cnt, m_type, m_held;
   logic [NH-1:0] hist [SYNC+1];

   always @(posedge clk) begin
      logic [NH-1:0] seen;
      bit take;
      if (rst) begin
         m_stop = 0; m_start = 0; m_cnt = 0; m_type = 0; m_held = 0;
         for (int k = 0; k <= SYNC; k++) hist[k] = '0;
      end else begin
         seen = (SYNC == 0) ? host_busy : hist[SYNC-1];
         take = !m_stop && sig_valid;
         if (run_begin) begin m_cnt = 0; m_type = 0; end
         if (take) begin
            m_cnt = (m_cnt + 1) % (1 << CW);
            m_type = sig_type;
         end
         if (!m_stop) begin
            m_start = 0;
            if (take) begin m_stop = 1; m_held = 1; end
         end else if (m_held >= HOLD && (seen & ~busy_mask) == '0) begin
            m_stop = 0; m_start = 1;
         end else begin
            m_start = 0; m_held++;
         end
         for (int k = SYNC; k > 0; k--) hist[k] = hist[k-1];
         hist[0] = host_busy;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
      end
   endtask

   // Compare against the model on every clock, away from the edge
   always @(negedge clk) begin
      cycles++;
      if (!rst && !done) begin
         check(stop_o == m_stop,   "R5 stop vs model",   stop_o,    m_stop);
         check(start_o == m_start, "R6 start vs model",  start_o,   m_start);
         check(evt_count == m_cnt, "R2 count vs model",  evt_count, m_cnt);
         check(trig_type == m_type,"R2 type vs model",   trig_type, m_type);
      end
      if (cycles > WATCHDOG && !done) begin
         done = 1;
         check(0, "watchdog expired", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic fire(input logic [TW-1:0] t);
      @(negedge clk); sig_valid = 1'b1; sig_type = t;
      @(negedge clk); sig_valid = 1'b0;
   endtask

   task automatic width_until_release(output int w);
      w = 0;
      while (stop_o) begin w++; @(negedge clk); end
   endtask

   initial begin
      int w;
      int c0;
      logic [TW-1:0] t0;
      repeat (3) @(negedge clk);
      check(stop_o == 0 && start_o == 0, "R1 reset outputs", stop_o + start_o, 0);
      check(evt_count == 0 && trig_type == 0, "R1 reset count/type", evt_count, 0);
      rst = 1'b0;
      @(negedge clk);
      check(stop_o == 0 && evt_count == 0, "R1 first cycle after reset", evt_count, 0);

      // R2/R4: idle hosts, minimum freeze width
      fire(5'd9);
      check(stop_o == 1, "R2 stop after signature", stop_o, 1);
      check(trig_type == 9 && evt_count == 1, "R2 latch type", trig_type, 9);
      width_until_release(w);
      check(w == HOLD, "R4 minimum freeze width", w, HOLD);
      check(start_o == 1, "R6 start at release", start_o, 1);
      @(negedge clk);
      check(start_o == 0, "R6 start single cycle", start_o, 0);

      // R5/R3: unmasked busy holds the freeze, extra flags ignored
      host_busy = 3'b010;
      fire(5'd3);
      c0 = evt_count; t0 = trig_type;
      repeat (3) fire(5'd17);
      repeat (4) @(negedge clk);
      check(stop_o == 1, "R5 held by busy", stop_o, 1);
      check(evt_count == c0, "R3 count unchanged", evt_count, c0);
      check(trig_type == t0, "R3 type unchanged", trig_type, t0);
      host_busy = 3'b000;
      @(negedge clk);
      width_until_release(w);
      check(w == SYNC, "R5 release delay after busy clears", w + 1, SYNC + 1);

      // R7: masked busy has no effect
      busy_mask = 3'b100; host_busy = 3'b100;
      repeat (3) @(negedge clk);
      fire(5'd4);
      width_until_release(w);
      check(w == HOLD, "R7 masked busy ignored", w, HOLD);
      host_busy = 3'b000; busy_mask = 3'b000;

      // R2 corner: flag in the start-pulse cycle is accepted
      fire(5'd21);
      while (!start_o) @(negedge clk);
      c0 = evt_count;
      sig_valid = 1'b1; sig_type = 5'd30;
      @(negedge clk); sig_valid = 1'b0;
      check(stop_o == 1 && trig_type == 30, "R2 flag in start cycle accepted", trig_type, 30);
      check(evt_count == ((c0 + 1) % 16), "R2 count in start cycle", evt_count, (c0 + 1) % 16);

      // R8: run_begin during freeze
      host_busy = 3'b001;
      @(negedge clk); run_begin = 1'b1;
      @(negedge clk); run_begin = 1'b0;
      check(evt_count == 0 && trig_type == 0, "R8 run_begin clears", evt_count, 0);
      check(stop_o == 1, "R8 run_begin keeps stop", stop_o, 1);
      host_busy = 3'b000;
      repeat (8) @(negedge clk);

      // R8 corner: run_begin together with an accepted flag
      @(negedge clk); run_begin = 1'b1; sig_valid = 1'b1; sig_type = 5'd12;
      @(negedge clk); run_begin = 1'b0; sig_valid = 1'b0;
      check(evt_count == 1 && trig_type == 12, "R8 run_begin with flag", evt_count, 1);
      width_until_release(w);

      // R9: wrap of the counter
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         fire(TW'(i));
         width_until_release(w);
      end
      check(evt_count == 0, "R9 counter wraps", evt_count, 0);

      // Mixed random traffic against the model
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         sig_valid = ($urandom_range(0, 3) == 0);
         sig_type  = TW'($urandom);
         host_busy = NH'($urandom_range(0, 7) & ($urandom_range(0, 1) ? 3'b111 : 3'b000));
         busy_mask = (i % 50 < 10) ? 3'b011 : 3'b000;
         run_begin = ($urandom_range(0, 60) == 0);
      end
      sig_valid = 0; run_begin = 0; host_busy = '0; busy_mask = '0;
      repeat (10) @(negedge clk);
      check(stop_o == 0, "R5 idle after traffic", stop_o, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule